// File: doc/BRIEF.md
# Pseudo-DMA Block Transfer Buffer

This block stages data between a host-side memory data window and a SCSI-side byte handshake engine. Data moves one full 512-byte block at a time. In the send direction the host fills the buffer byte by byte and the SCSI side then drains it. In the initiator-receive direction the SCSI side fills the buffer and the host then reads it out byte by byte.

A host-visible ready bit passes ownership of the buffer back and forth between the two sides. A block counter is loaded at the start of a transfer and is decremented after every block that crosses the SCSI side. When the counter reaches zero the block flags the end of the transfer, and it can optionally raise an interrupt. Clearing the DMA enable after completion returns the engine to idle.

The SCSI side moves one byte per handshake. It presents the byte, waits for the target's request, and then pulses ACK for one cycle. The host side takes one byte per access cycle. A read returns its data on the cycle after the access.

Top module: `pdma_xfer_buf`

## Requirements
- R1: After reset, `status` reads 0x04, `blk_left` is 0, `xfer_mode` is 0 (idle), and `blk_loaded`, `end_of_dma`, `last_byte_sent` and `irq` are all 0.
- R2: A `start_send` or `start_recv` pulse loads `blk_left` with `xfer_len` shifted right by 9, truncated to 8 bits. It also sets `blk_loaded`, sets `status` bit 2, and sets `xfer_mode` to 1 for send or 2 for receive. If both pulses arrive together, send wins.
- R3: In send mode, each `host_wr` while the host position is below 512 stores `host_wdata` at that position and advances the position. The write that fills position 511 clears `status` bit 2 on the next cycle. A write made at position 512 alters no buffered byte.
- R4: A `host_rd` in receive mode below position 512 returns the next buffered byte on `host_rdata` one cycle later and advances the position. The 512th read clears `status` bit 2. A read at position 512, or a read outside receive mode, returns 0xFF.
- R5: The SCSI side runs only while the host position is 512, `status` bit 2 is set, a block is loaded and `dma_en` is high. For each byte, `scsi_ack` pulses high for exactly one cycle, and only after `scsi_req` has been seen high. In send mode `scsi_dout` holds the buffered byte, stable across the ACK cycle. In receive mode `scsi_din` is stored during the ACK cycle.
- R6: After the 512th SCSI byte, both positions return to 0, `status` bit 1 is cleared and `blk_left` decrements by one.
- R7: When `blk_left` reaches 0, `blk_loaded` clears and `end_of_dma` sets. `last_byte_sent` sets only in send mode. `irq` sets only if `eop_irq_en` is high.
- R8: If blocks remain, the host position is 512 and `status` bit 2 is clear, bit 2 sets again on the next cycle. While the host position is below 512, no SCSI byte moves.
- R9: With `dma_en` low and no block loaded, a non-idle engine returns to idle and clears `end_of_dma`, `last_byte_sent` and `irq`.
- R10: A `flag_set` pulse sets `status` bit 1. If it falls in the same cycle as the end-of-block clear of R6, the set wins.
- R11: The host side and the SCSI side never use the buffer in the same cycle. Whenever `scsi_ack` is high, the buffer belongs to the SCSI side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_send | input | 1 | Start a host-to-SCSI transfer |
| start_recv | input | 1 | Start a SCSI-to-host transfer |
| xfer_len | input | 24 | Transfer length in bytes |
| dma_en | input | 1 | DMA mode enable |
| eop_irq_en | input | 1 | End-of-process interrupt enable |
| flag_set | input | 1 | Sets status bit 1 |
| host_wr | input | 1 | Host data window write |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host data window read |
| host_rdata | output | 8 | Host read byte, valid one cycle after `host_rd` |
| scsi_req | input | 1 | Target request |
| scsi_din | input | 8 | Byte from the SCSI bus |
| scsi_dout | output | 8 | Byte driven to the SCSI bus |
| scsi_ack | output | 1 | One-cycle acknowledge per byte |
| status | output | 8 | Bit 2 ready, bit 1 flag, other bits 0 |
| blk_left | output | 8 | Remaining block count |
| blk_loaded | output | 1 | A transfer is loaded |
| end_of_dma | output | 1 | Transfer finished |
| last_byte_sent | output | 1 | Send transfer finished |
| irq | output | 1 | End-of-process interrupt |
| xfer_mode | output | 2 | 0 idle, 1 send, 2 receive |

## Verification
Two functions can land in the same cycle: a `flag_set` pulse, and the end-of-block wrap that clears the same status bit. The bench counts ACK pulses on the SCSI side. It fires `flag_set` during the ACK of the last byte of the final block, so the pulse coincides with the wrap edge. After the wrap it expects `status` bit 1 to read set. A second pulse, fired during the first block's opening byte, must be wiped by that block's wrap. Together these show that both the clear and the set priority are effective.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
    typedef enum logic [1:0] {
        XM_IDLE = 2'd0,
        XM_SEND = 2'd1,
        XM_RECV = 2'd2
    } xmode_e;

    typedef enum logic [1:0] {
        PH_FETCH = 2'd0,
        PH_SHOW  = 2'd1,
        PH_ACK   = 2'd2
    } phase_e;

    localparam int READY_BIT = 2;
    localparam int FLAG_BIT  = 1;
endpackage

// File: rtl/pdma_buf_mem.sv
module pdma_buf_mem #(
    parameter int DEPTH = 512,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // single write port, registered read port
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/pdma_ack_seq.sv
module pdma_ack_seq
    import pdma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic scsi_req,
    output logic scsi_ack,
    output logic byte_done
);
    phase_e ph_d, ph_q;

    // fetch address, show byte until request, then one ACK cycle
    always_comb begin
        ph_d = ph_q;
        if (!run) begin
            ph_d = PH_FETCH;
        end else begin
            case (ph_q)
                PH_FETCH: ph_d = PH_SHOW;
                PH_SHOW:  ph_d = scsi_req ? PH_ACK : PH_SHOW;
                default:  ph_d = PH_FETCH;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= PH_FETCH;
        end else begin
            ph_q <= ph_d;
        end
    end

    assign scsi_ack  = (ph_q == PH_ACK);
    assign byte_done = (ph_q == PH_ACK);
endmodule

// File: rtl/pdma_ctrl.sv
module pdma_ctrl
    import pdma_pkg::*;
#(
    parameter int BLK_BYTES = 512,
    parameter int LEN_W     = 24,
    parameter int CNT_W     = 8,
    parameter int DW        = 8,
    localparam int AW       = $clog2(BLK_BYTES),
    localparam int PW       = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_send,
    input  logic             start_recv,
    input  logic [LEN_W-1:0] xfer_len,
    input  logic             dma_en,
    input  logic             eop_irq_en,
    input  logic             flag_set,
    input  logic             host_wr,
    input  logic [DW-1:0]    host_wdata,
    input  logic             host_rd,
    input  logic             byte_done,
    input  logic [DW-1:0]    scsi_din,
    output logic             run,
    output logic             host_side,
    output logic             mem_we,
    output logic [AW-1:0]    mem_waddr,
    output logic [DW-1:0]    mem_wdata,
    output logic [AW-1:0]    mem_raddr,
    output logic             rd_ff,
    output logic [7:0]       status,
    output logic [CNT_W-1:0] blk_left,
    output logic             blk_loaded,
    output logic             end_of_dma,
    output logic             last_byte_sent,
    output logic             irq,
    output logic [1:0]       xfer_mode
);
    localparam logic [PW-1:0] FULL_POS = PW'(BLK_BYTES);
    localparam logic [PW-1:0] LAST_HPOS = PW'(BLK_BYTES - 1);
    localparam logic [AW-1:0] LAST_SPOS = AW'(BLK_BYTES - 1);

    typedef struct packed {
        xmode_e           mode;
        logic [PW-1:0]    hpos;
        logic [AW-1:0]    spos;
        logic [CNT_W-1:0] blk;
        logic             loaded;
        logic             ready;
        logic             flag;
        logic             eod;
        logic             lbs;
        logic             irq;
        logic             rd_ff;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        mode:   XM_IDLE,
        hpos:   FULL_POS,
        spos:   '0,
        blk:    '0,
        loaded: 1'b0,
        ready:  1'b1,
        flag:   1'b0,
        eod:    1'b0,
        lbs:    1'b0,
        irq:    1'b0,
        rd_ff:  1'b0
    };

    ctl_t q, d;
    logic host_we, host_re, scsi_we;

    // buffer belongs to the host while its position is below a full block
    assign host_side = ~q.hpos[AW];
    assign host_we   = host_wr && (q.mode == XM_SEND) && host_side;
    assign host_re   = host_rd && (q.mode == XM_RECV) && host_side;
    assign scsi_we   = byte_done && (q.mode == XM_RECV);
    assign run       = (q.mode != XM_IDLE) && dma_en && q.loaded && q.ready && q.hpos[AW];

    always_comb begin
        d       = q;
        d.rd_ff = 1'b0;

        if (host_we || host_re) begin
            d.hpos = q.hpos + 1'b1;
            if (q.hpos == LAST_HPOS) begin
                d.ready = 1'b0;
            end
        end
        if (host_rd && !host_re) begin
            d.rd_ff = 1'b1;
        end

        if (byte_done) begin
            if (q.spos == LAST_SPOS) begin
                d.spos = '0;
                d.hpos = '0;
                d.flag = 1'b0;
                d.blk  = q.blk - 1'b1;
                if (q.blk == CNT_W'(1)) begin
                    d.loaded = 1'b0;
                    d.eod    = 1'b1;
                    if (q.mode == XM_SEND) begin
                        d.lbs = 1'b1;
                    end
                    if (eop_irq_en) begin
                        d.irq = 1'b1;
                    end
                end
            end else begin
                d.spos = q.spos + 1'b1;
            end
        end

        // hand the next block to the SCSI side once the host is done
        if (q.loaded && dma_en && (q.mode != XM_IDLE) && q.hpos[AW] && !q.ready) begin
            d.ready = 1'b1;
        end

        if (flag_set) begin
            d.flag = 1'b1;
        end

        if (!dma_en && !q.loaded && (q.mode != XM_IDLE)) begin
            d.mode = XM_IDLE;
            d.eod  = 1'b0;
            d.lbs  = 1'b0;
            d.irq  = 1'b0;
        end

        if (start_send || start_recv) begin
            d.mode   = start_send ? XM_SEND : XM_RECV;
            d.blk    = CNT_W'(xfer_len >> AW);
            d.loaded = 1'b1;
            d.ready  = 1'b1;
            d.spos   = '0;
            d.hpos   = start_send ? '0 : FULL_POS;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= CTL_RST;
        end else begin
            q <= d;
        end
    end

    assign mem_we         = host_we || scsi_we;
    assign mem_waddr      = host_side ? q.hpos[AW-1:0] : q.spos;
    assign mem_raddr      = host_side ? q.hpos[AW-1:0] : q.spos;
    assign mem_wdata      = host_side ? host_wdata : scsi_din;
    assign rd_ff          = q.rd_ff;
    assign blk_left       = q.blk;
    assign blk_loaded     = q.loaded;
    assign end_of_dma     = q.eod;
    assign last_byte_sent = q.lbs;
    assign irq            = q.irq;
    assign xfer_mode      = q.mode;

    always_comb begin
        status            = 8'h00;
        status[READY_BIT] = q.ready;
        status[FLAG_BIT]  = q.flag;
    end
endmodule

// File: rtl/pdma_xfer_buf.sv
module pdma_xfer_buf #(
    parameter int BLK_BYTES = 512,
    parameter int LEN_W     = 24,
    parameter int CNT_W     = 8,
    parameter int DW        = 8,
    localparam int AW       = $clog2(BLK_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_send,
    input  logic             start_recv,
    input  logic [LEN_W-1:0] xfer_len,
    input  logic             dma_en,
    input  logic             eop_irq_en,
    input  logic             flag_set,
    input  logic             host_wr,
    input  logic [DW-1:0]    host_wdata,
    input  logic             host_rd,
    output logic [DW-1:0]    host_rdata,
    input  logic             scsi_req,
    input  logic [DW-1:0]    scsi_din,
    output logic [DW-1:0]    scsi_dout,
    output logic             scsi_ack,
    output logic [7:0]       status,
    output logic [CNT_W-1:0] blk_left,
    output logic             blk_loaded,
    output logic             end_of_dma,
    output logic             last_byte_sent,
    output logic             irq,
    output logic [1:0]       xfer_mode
);
    logic          run, host_side, byte_done, rd_ff, mem_we;
    logic [AW-1:0] mem_waddr, mem_raddr;
    logic [DW-1:0] mem_wdata, mem_rdata;

    pdma_ctrl #(
        .BLK_BYTES (BLK_BYTES),
        .LEN_W     (LEN_W),
        .CNT_W     (CNT_W),
        .DW        (DW)
    ) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_send     (start_send),
        .start_recv     (start_recv),
        .xfer_len       (xfer_len),
        .dma_en         (dma_en),
        .eop_irq_en     (eop_irq_en),
        .flag_set       (flag_set),
        .host_wr        (host_wr),
        .host_wdata     (host_wdata),
        .host_rd        (host_rd),
        .byte_done      (byte_done),
        .scsi_din       (scsi_din),
        .run            (run),
        .host_side      (host_side),
        .mem_we         (mem_we),
        .mem_waddr      (mem_waddr),
        .mem_wdata      (mem_wdata),
        .mem_raddr      (mem_raddr),
        .rd_ff          (rd_ff),
        .status         (status),
        .blk_left       (blk_left),
        .blk_loaded     (blk_loaded),
        .end_of_dma     (end_of_dma),
        .last_byte_sent (last_byte_sent),
        .irq            (irq),
        .xfer_mode      (xfer_mode)
    );

    pdma_ack_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .scsi_req  (scsi_req),
        .scsi_ack  (scsi_ack),
        .byte_done (byte_done)
    );

    pdma_buf_mem #(
        .DEPTH (BLK_BYTES),
        .DW    (DW)
    ) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    assign host_rdata = rd_ff ? {DW{1'b1}} : mem_rdata;
    assign scsi_dout  = mem_rdata;
endmodule

// File: rtl/pdma_xfer_buf_chk.sv
module pdma_xfer_buf_chk #(
    parameter int CNT_W = 8,
    parameter int DW    = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dma_en,
    input logic             eop_irq_en,
    input logic             scsi_ack,
    input logic [DW-1:0]    scsi_dout,
    input logic [1:0]       xfer_mode,
    input logic [CNT_W-1:0] blk_left,
    input logic             blk_loaded,
    input logic             end_of_dma,
    input logic             irq,
    input logic             host_side
);
    // R5
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scsi_ack |=> !scsi_ack);

    // R5
    dout_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scsi_ack && xfer_mode == 2'd1) |-> $stable(scsi_dout));

    // R7
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(eop_irq_en));

    // R7
    eod_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(end_of_dma) |-> (blk_left == '0));

    // R7
    unload_eod_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(blk_loaded) |-> end_of_dma);

    // R9
    idle_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_mode == 2'd0 && $past(xfer_mode) != 2'd0) |-> (!$past(dma_en) && !$past(blk_loaded)));

    // R11
    side_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scsi_ack |-> !host_side);
endmodule

bind pdma_xfer_buf pdma_xfer_buf_chk #(
    .CNT_W (CNT_W),
    .DW    (DW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dma_en     (dma_en),
    .eop_irq_en (eop_irq_en),
    .scsi_ack   (scsi_ack),
    .scsi_dout  (scsi_dout),
    .xfer_mode  (xfer_mode),
    .blk_left   (blk_left),
    .blk_loaded (blk_loaded),
    .end_of_dma (end_of_dma),
    .irq        (irq),
    .host_side  (host_side)
);

// File: tb/pdma_xfer_buf_bench.sv
module pdma_xfer_buf_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_send = 1'b0, start_recv = 1'b0;
    logic [23:0] xfer_len = '0;
    logic        dma_en = 1'b0, eop_irq_en = 1'b0, flag_set = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0]  host_wdata = '0, host_rdata;
    logic        scsi_req = 1'b1;
    logic [7:0]  scsi_din, scsi_dout;
    logic        scsi_ack;
    logic [7:0]  status, blk_left;
    logic        blk_loaded, end_of_dma, last_byte_sent, irq;
    logic [1:0]  xfer_mode;

    int checks = 0, fails = 0;
    bit done = 0;
    int ack_cnt = 0, done_cnt = 0, rx_base = 0, flag_at = -1;
    bit prev_ack = 0;
    logic [7:0] sent [2048];

    function automatic logic [7:0] snd_pat(int k);
        return 8'((k * 7) + 3);
    endfunction

    function automatic logic [7:0] rcv_pat(int k);
        return 8'((k * 13) + 90);
    endfunction

    assign scsi_din = rcv_pat(done_cnt - rx_base);

    pdma_xfer_buf u_pdma_xfer_buf (
        .clk(clk), .rst_n(rst_n), .start_send(start_send), .start_recv(start_recv),
        .xfer_len(xfer_len), .dma_en(dma_en), .eop_irq_en(eop_irq_en), .flag_set(flag_set),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
        .scsi_req(scsi_req), .scsi_din(scsi_din), .scsi_dout(scsi_dout), .scsi_ack(scsi_ack),
        .status(status), .blk_left(blk_left), .blk_loaded(blk_loaded), .end_of_dma(end_of_dma),
        .last_byte_sent(last_byte_sent), .irq(irq), .xfer_mode(xfer_mode)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // SCSI target model: records sent bytes, counts handshakes, fires flag_set on request
    always @(negedge clk) begin
        flag_set = 1'b0;
        if (scsi_ack && !prev_ack) begin
            sent[ack_cnt % 2048] = scsi_dout;
            if (ack_cnt == flag_at) flag_set = 1'b1;
            ack_cnt++;
        end
        if (prev_ack && !scsi_ack) done_cnt++;
        prev_ack = scsi_ack;
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_blk(string req, logic [7:0] target);
        int n = 0;
        while (blk_left !== target && n < 4000) begin
            @(negedge clk);
            n++;
        end
        chk(req, "block count reached", 32'(blk_left), 32'(target));
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic t_reset();
        chk("R1", "status", 32'(status), 32'h04);
        chk("R1", "blk_left", 32'(blk_left), 32'h0);
        chk("R1", "mode", 32'(xfer_mode), 32'h0);
        chk("R1", "flags", {28'h0, blk_loaded, end_of_dma, last_byte_sent, irq}, 32'h0);
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        chk("R4", "idle read", 32'(host_rdata), 32'hFF);
    endtask

    task automatic t_send();
        int base = ack_cnt;
        int bad;
        dma_en = 1'b1;
        eop_irq_en = 1'b1;
        flag_at = base;
        xfer_len = 24'd1024;
        start_send = 1'b1;
        start_recv = 1'b1;
        @(negedge clk);
        start_send = 1'b0;
        start_recv = 1'b0;
        chk("R2", "send wins", 32'(xfer_mode), 32'h1);
        chk("R2", "blocks", 32'(blk_left), 32'h2);
        chk("R2", "loaded+ready", {30'h0, blk_loaded, status[2]}, 32'h3);
        for (int i = 0; i < 512; i++) begin
            host_wr = 1'b1;
            host_wdata = snd_pat(i);
            @(negedge clk);
        end
        chk("R3", "ready cleared at full", 32'(status[2]), 32'h0);
        host_wdata = 8'hEE;
        @(negedge clk);
        host_wr = 1'b0;
        wait_blk("R6", 8'd1);
        bad = 0;
        for (int i = 0; i < 512; i++) if (sent[(base + i) % 2048] !== snd_pat(i)) bad++;
        chk("R3", "block 0 bytes sent (extra write ignored)", 32'(bad), 32'h0);
        chk("R5", "ack count block 0", 32'(ack_cnt - base), 32'd512);
        chk("R6", "status after wrap", 32'(status), 32'h04);
        flag_at = base + 1023;
        for (int i = 0; i < 512; i++) begin
            host_wr = 1'b1;
            host_wdata = snd_pat(512 + i);
            @(negedge clk);
        end
        host_wr = 1'b0;
        wait_blk("R7", 8'd0);
        bad = 0;
        for (int i = 0; i < 512; i++) if (sent[(base + 512 + i) % 2048] !== snd_pat(512 + i)) bad++;
        chk("R5", "block 1 bytes sent", 32'(bad), 32'h0);
        chk("R7", "eod,lbs,loaded,irq", {28'h0, end_of_dma, last_byte_sent, blk_loaded, irq}, 32'b1101);
        chk("R10", "flag set beats wrap clear", 32'(status[1]), 32'h1);
        dma_en = 1'b0;
        @(negedge clk);
        chk("R9", "idle mode", 32'(xfer_mode), 32'h0);
        chk("R9", "flags cleared", {29'h0, end_of_dma, last_byte_sent, irq}, 32'h0);
    endtask

    task automatic read_block(string req, int first);
        int bad = 0;
        for (int i = 0; i < 512; i++) begin
            host_rd = 1'b1;
            @(negedge clk);
            if (host_rdata !== rcv_pat(first + i)) bad++;
        end
        host_rd = 1'b0;
        chk(req, "block read data", 32'(bad), 32'h0);
        chk("R4", "ready cleared after last read", 32'(status[2]), 32'h0);
    endtask

    task automatic t_recv();
        int held;
        dma_en = 1'b1;
        eop_irq_en = 1'b0;
        rx_base = done_cnt;
        xfer_len = 24'd1124;
        start_recv = 1'b1;
        @(negedge clk);
        start_recv = 1'b0;
        chk("R2", "recv mode", 32'(xfer_mode), 32'h2);
        chk("R2", "truncated blocks", 32'(blk_left), 32'h2);
        chk("R2", "ready", 32'(status[2]), 32'h1);
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        chk("R4", "read of empty buffer", 32'(host_rdata), 32'hFF);
        wait_blk("R6", 8'd1);
        held = ack_cnt;
        repeat (40) @(negedge clk);
        chk("R8", "SCSI waits while host reads", 32'(ack_cnt), 32'(held));
        read_block("R5", 0);
        wait_blk("R8", 8'd0);
        chk("R7", "eod,lbs,loaded,irq", {28'h0, end_of_dma, last_byte_sent, blk_loaded, irq}, 32'b1000);
        read_block("R5", 512);
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        chk("R4", "read past end", 32'(host_rdata), 32'hFF);
        dma_en = 1'b0;
        @(negedge clk);
        chk("R9", "idle after recv", 32'(xfer_mode), 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_send();
        t_recv();
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule